// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the write-side command interpreter of a parallel NOR flash, modelled synchronously. Each sampled bus write carries an address and a data word; the low byte of the data is the command code. The sequencer follows the two-write unlock pattern that must come before every real command. It recognises the commands for program, chip erase, sector erase, identification read, erase suspend, erase resume and the return-to-read reset. From these it keeps a mode register that says what the device is doing. The modes are read-array, ID-read, program-busy, erase-busy, erase-suspended and fail.

Whenever a program or an erase is accepted, the block sends a one-cycle start pulse to a separate execution engine. The pulse comes with the operation type, the target address and the data word. The engine reports back with a done pulse or a fail pulse. Suspend and resume requests also go to the engine as one-cycle pulses. A byte-mode input selects which pair of unlock addresses applies. An asynchronous active-low reset puts the sequencer back in read-array mode and drops any sequence that was partly entered.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is asserted, and after it is released, mode is read-array (0) and no start, suspend or resume pulse is present. Asserting reset during a busy mode returns to read-array at once, and a command must then be entered again from the start.
- R2: Only the low 12 address bits are compared. The first unlock write is data AA at 555h in word mode (byte_mode=0) or at AAAh in byte mode. The second unlock write is data 55 at 2AAh in word mode or at 555h in byte mode. The command address equals the first unlock address. A program sequence is: unlock, then A0 at the command address, then one write of any address and data. One clock later, start is high, start_op is 1 (program), start_addr and start_data hold that write, and mode is program-busy (2).
- R3: A write that does not match the next expected step of a sequence, whether by data or by address, returns the tracker to idle. No operation starts, and a full sequence afterwards still works.
- R4: Chip erase is unlock, 80, unlock, then 10 at the command address. It gives start with start_op 2 and mode erase-busy (3).
- R5: Sector erase is unlock, 80, unlock, then 30 at any address. It gives start with start_op 3 and start_addr equal to that address.
- R6: Unlock followed by 90 at the command address enters ID-read mode (1). The block stays in that mode across any writes other than F0. F0 at any address returns it to read-array.
- R7: F0 written partway through a sequence drops the partial sequence. The steps that follow are then judged from idle.
- R8: In program-busy mode every write is ignored, F0 included. An engine done pulse returns the block to the mode it was in before the program started. An engine fail pulse enters fail mode (5).
- R9: Fail mode is held through every write except F0. F0 returns the block to read-array.
- R10: In erase-busy mode, when the erase is a sector erase, B0 at any address enters erase-suspended mode (4) with a one-cycle suspend_req. During a chip erase, B0 is ignored, and so is every other write. Engine done returns the block to read-array; engine fail enters fail mode.
- R11: In erase-suspended mode, 30 written with no sequence pending resumes the erase (mode 3) with a one-cycle resume_req. A program sequence is accepted in this mode. The ID and erase commands are refused, and the block stays suspended.
- R12: start, suspend_req and resume_req never occur in the same cycle, and each one lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low byte is the command code |
| eng_done | input | 1 | Engine finished the current operation |
| eng_fail | input | 1 | Engine reports the operation failed |
| mode | output | 3 | 0 read, 1 ID, 2 program, 3 erase, 4 suspended, 5 fail |
| start | output | 1 | One-cycle operation launch |
| start_op | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| start_addr | output | ADDR_W | Target address of the launched operation |
| start_data | output | DATA_W | Program data of the launched operation |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
Every result of a write appears exactly one clock after the edge that samples that write: the mode change, the start, suspend and resume pulses, and the launch fields. The effect of an engine done or fail pulse is due with the same one-cycle latency. The bench drives each write on a falling edge and removes it on the next falling edge. It checks the outputs just after that second falling edge, so each check reads the register that the single intervening rising edge loaded. Pulse counts are gathered on falling edges, which keeps them clear of the edge where the pulses change.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_ID    = 3'd1,
    MODE_PROG  = 3'd2,
    MODE_ERASE = 3'd3,
    MODE_SUSP  = 3'd4,
    MODE_FAIL  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_CHIP = 2'd2,
    OP_SECT = 2'd3
  } op_e;

  localparam int unsigned MATCH_W = 12;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_RESET = 8'hF0;

  localparam logic [MATCH_W-1:0] ADR_WORD_A = 12'h555;
  localparam logic [MATCH_W-1:0] ADR_WORD_B = 12'h2AA;
  localparam logic [MATCH_W-1:0] ADR_BYTE_A = 12'hAAA;
  localparam logic [MATCH_W-1:0] ADR_BYTE_B = 12'h555;

endpackage

// File: rtl/fcs_addr_match.sv
module fcs_addr_match
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_mode,
  output logic              hit_a,
  output logic              hit_b
);

  logic [MATCH_W-1:0] low;

  generate
    if (ADDR_W >= MATCH_W) begin : g_slice
      assign low = addr[MATCH_W-1:0];
    end else begin : g_pad
      assign low = {{(MATCH_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  assign hit_a = (low == (byte_mode ? ADR_BYTE_A : ADR_WORD_A));
  assign hit_b = (low == (byte_mode ? ADR_BYTE_B : ADR_WORD_B));

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       susp_mode,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic [7:0] cmd,
  output logic       ev_prog,
  output logic       ev_id,
  output logic       ev_chip,
  output logic       ev_sect,
  output logic       idle
);

  typedef enum logic [2:0] {
    Q_IDLE, Q_U1, Q_U2, Q_PGA, Q_E3, Q_E4, Q_E5
  } step_e;

  step_e st, st_n;

  always_comb begin
    st_n    = st;
    ev_prog = 1'b0;
    ev_id   = 1'b0;
    ev_chip = 1'b0;
    ev_sect = 1'b0;
    if (en) begin
      case (st)
        Q_IDLE: if (hit_a && cmd == CMD_UNLK1) st_n = Q_U1;
        Q_U1:   st_n = (hit_b && cmd == CMD_UNLK2) ? Q_U2 : Q_IDLE;
        Q_U2: begin
          st_n = Q_IDLE;
          if (hit_a && cmd == CMD_PROG)                    st_n  = Q_PGA;
          else if (!susp_mode && hit_a && cmd == CMD_ERASE) st_n  = Q_E3;
          else if (!susp_mode && hit_a && cmd == CMD_ID)    ev_id = 1'b1;
        end
        Q_PGA: begin
          st_n    = Q_IDLE;
          ev_prog = 1'b1;
        end
        Q_E3:   st_n = (hit_a && cmd == CMD_UNLK1) ? Q_E4 : Q_IDLE;
        Q_E4:   st_n = (hit_b && cmd == CMD_UNLK2) ? Q_E5 : Q_IDLE;
        Q_E5: begin
          st_n = Q_IDLE;
          if (hit_a && cmd == CMD_CHIP) ev_chip = 1'b1;
          else if (cmd == CMD_SECT)     ev_sect = 1'b1;
        end
        default: st_n = Q_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= Q_IDLE;
    else        st <= st_n;
  end

  assign idle = (st == Q_IDLE);

endmodule

// File: rtl/fcs_mode.sv
module fcs_mode
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ev_prog,
  input  logic              ev_id,
  input  logic              ev_chip,
  input  logic              ev_sect,
  input  logic              seq_idle,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic              seq_en,
  output logic              susp_mode,
  output logic [2:0]        mode,
  output logic              start,
  output logic [1:0]        start_op,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_data,
  output logic              suspend_req,
  output logic              resume_req
);

  mode_e      md, md_n;
  logic       sect_q, sect_n;
  logic       sprog_q, sprog_n;
  logic       launch, sus_n, res_n;
  op_e        op_q, op_n;
  logic [7:0] cmd;

  assign cmd       = wr_data[7:0];
  assign seq_en    = wr_en && (md == MODE_READ || md == MODE_SUSP);
  assign susp_mode = (md == MODE_SUSP);

  always_comb begin
    md_n    = md;
    sect_n  = sect_q;
    sprog_n = sprog_q;
    launch  = 1'b0;
    op_n    = op_q;
    sus_n   = 1'b0;
    res_n   = 1'b0;
    case (md)
      MODE_READ: begin
        if (ev_prog) begin
          md_n = MODE_PROG; launch = 1'b1; op_n = OP_PROG; sprog_n = 1'b0;
        end else if (ev_chip) begin
          md_n = MODE_ERASE; launch = 1'b1; op_n = OP_CHIP; sect_n = 1'b0;
        end else if (ev_sect) begin
          md_n = MODE_ERASE; launch = 1'b1; op_n = OP_SECT; sect_n = 1'b1;
        end else if (ev_id) begin
          md_n = MODE_ID;
        end
      end
      MODE_SUSP: begin
        if (ev_prog) begin
          md_n = MODE_PROG; launch = 1'b1; op_n = OP_PROG; sprog_n = 1'b1;
        end else if (wr_en && seq_idle && cmd == CMD_SECT) begin
          md_n = MODE_ERASE; res_n = 1'b1;
        end
      end
      MODE_ID, MODE_FAIL: begin
        if (wr_en && cmd == CMD_RESET) md_n = MODE_READ;
      end
      MODE_PROG: begin
        if (eng_fail) begin
          md_n = MODE_FAIL; sprog_n = 1'b0;
        end else if (eng_done) begin
          md_n    = sprog_q ? MODE_SUSP : MODE_READ;
          sprog_n = 1'b0;
        end
      end
      MODE_ERASE: begin
        if (eng_fail)      md_n = MODE_FAIL;
        else if (eng_done) md_n = MODE_READ;
        else if (wr_en && sect_q && cmd == CMD_SUSP) begin
          md_n = MODE_SUSP; sus_n = 1'b1;
        end
      end
      default: md_n = MODE_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md          <= MODE_READ;
      sect_q      <= 1'b0;
      sprog_q     <= 1'b0;
      op_q        <= OP_NONE;
      start       <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
    end else begin
      md          <= md_n;
      sect_q      <= sect_n;
      sprog_q     <= sprog_n;
      op_q        <= op_n;
      start       <= launch;
      suspend_req <= sus_n;
      resume_req  <= res_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      start_data <= '0;
    end else if (launch) begin
      start_addr <= wr_addr;
      start_data <= wr_data;
    end
  end

  assign mode     = md;
  assign start_op = op_q;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic [2:0]        mode,
  output logic              start,
  output logic [1:0]        start_op,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_data,
  output logic              suspend_req,
  output logic              resume_req
);

  logic hit_a, hit_b;
  logic seq_en, susp_mode, seq_idle;
  logic ev_prog, ev_id, ev_chip, ev_sect;

  fcs_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .addr      (wr_addr),
    .byte_mode (byte_mode),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
  );

  fcs_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (seq_en),
    .susp_mode (susp_mode),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .cmd       (wr_data[7:0]),
    .ev_prog   (ev_prog),
    .ev_id     (ev_id),
    .ev_chip   (ev_chip),
    .ev_sect   (ev_sect),
    .idle      (seq_idle)
  );

  fcs_mode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ev_prog     (ev_prog),
    .ev_id       (ev_id),
    .ev_chip     (ev_chip),
    .ev_sect     (ev_sect),
    .seq_idle    (seq_idle),
    .eng_done    (eng_done),
    .eng_fail    (eng_fail),
    .seq_en      (seq_en),
    .susp_mode   (susp_mode),
    .mode        (mode),
    .start       (start),
    .start_op    (start_op),
    .start_addr  (start_addr),
    .start_data  (start_data),
    .suspend_req (suspend_req),
    .resume_req  (resume_req)
  );

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk
  import fcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] cmd,
  input logic       eng_done,
  input logic       eng_fail,
  input logic [2:0] mode,
  input logic       start,
  input logic [1:0] start_op,
  input logic       suspend_req,
  input logic       resume_req
);

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, suspend_req, resume_req}));

  // R12
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (mode == MODE_PROG || mode == MODE_ERASE));

  // R2
  prog_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == OP_PROG) |-> mode == MODE_PROG);

  // R8
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROG && !eng_done && !eng_fail) |=> mode == MODE_PROG);

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAIL && !(wr_en && cmd == CMD_RESET)) |=> mode == MODE_FAIL);

  // R6
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ID && !(wr_en && cmd == CMD_RESET)) |=> mode == MODE_ID);

  // R10
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> (mode == MODE_SUSP && $past(mode) == MODE_ERASE));

  // R11
  resume_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (mode == MODE_ERASE && $past(mode) == MODE_SUSP));

endmodule

bind flash_cmd_seq fcs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .cmd         (wr_data[7:0]),
  .eng_done    (eng_done),
  .eng_fail    (eng_fail),
  .mode        (mode),
  .start       (start),
  .start_op    (start_op),
  .suspend_req (suspend_req),
  .resume_req  (resume_req)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, byte_mode, wr_en, eng_done, eng_fail;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0]    mode;
  logic          start, suspend_req, resume_req;
  logic [1:0]    start_op;
  logic [AW-1:0] start_addr;
  logic [DW-1:0] start_data;

  int checks = 0, failures = 0;
  int start_cnt = 0, susp_cnt = 0, resm_cnt = 0, multi_cnt = 0, long_cnt = 0;
  logic prev_pulse = 1'b0;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_done(eng_done), .eng_fail(eng_fail),
    .mode(mode), .start(start), .start_op(start_op), .start_addr(start_addr),
    .start_data(start_data), .suspend_req(suspend_req), .resume_req(resume_req)
  );

  always @(negedge clk) begin
    if (start) start_cnt++;
    if (suspend_req) susp_cnt++;
    if (resume_req) resm_cnt++;
    if (int'(start) + int'(suspend_req) + int'(resume_req) > 1) multi_cnt++;
    if (prev_pulse && (start || suspend_req || resume_req)) long_cnt++;
    prev_pulse = start || suspend_req || resume_req;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] fa();
    return byte_mode ? 12'hAAA : 12'h555;
  endfunction

  function automatic logic [11:0] fb();
    return byte_mode ? 12'h555 : 12'h2AA;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic unlock();
    wr({8'h00, fa()}, 16'h00AA);
    wr({8'h00, fb()}, 16'h0055);
  endtask

  task automatic eng(input bit fail);
    @(negedge clk);
    if (fail) eng_fail = 1'b1; else eng_done = 1'b1;
    @(negedge clk);
    eng_fail = 1'b0; eng_done = 1'b0;
    #1;
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    unlock();
    wr({8'h00, fa()}, 16'h00A0);
    wr(a, d);
  endtask

  task automatic do_erase_pre();
    unlock();
    wr({8'h00, fa()}, 16'h0080);
    unlock();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int sc;
    rst_n = 1'b0; byte_mode = 1'b0; wr_en = 1'b0; eng_done = 1'b0; eng_fail = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "mode in reset", mode, 0);
    chk("R1", "start in reset", start, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "mode after reset", mode, 0);
    chk("R1", "pulses after reset", start_cnt + susp_cnt + resm_cnt, 0);

    // Sweep every command byte after an unlock, both address modes
    for (int bm = 0; bm < 2; bm++) begin
      for (int d = 0; d < 256; d++) begin
        logic [AW-1:0] ta;
        byte_mode = bm[0];
        sc = start_cnt;
        unlock();
        wr({d[7:0], fa()}, {8'h00, d[7:0]});
        if (d == 'hA0) begin
          ta = {d[7:0], 12'h3C5} ^ AW'(bm);
          wr(ta, {d[7:0], ~d[7:0]});
          chk("R2", "program start count", start_cnt, sc + 1);
          chk("R2", "program op", start_op, 1);
          chk("R2", "program addr", start_addr, ta);
          chk("R2", "program data", start_data, {d[7:0], ~d[7:0]});
          chk("R2", "program mode", mode, 2);
          eng(1'b0);
          chk("R8", "done returns read", mode, 0);
        end else if (d == 'h80) begin
          unlock();
          wr({8'h5A, fa()}, 16'h0010);
          chk("R4", "chip erase start", start_cnt, sc + 1);
          chk("R4", "chip erase op", start_op, 2);
          chk("R4", "chip erase mode", mode, 3);
          eng(1'b0);
          chk("R10", "erase done read", mode, 0);
        end else if (d == 'h90) begin
          chk("R6", "id entered", mode, 1);
          wr(20'h00555, 16'h00AA);
          wr(20'h00000, 16'h0000);
          chk("R6", "id held", mode, 1);
          wr(20'h12345, 16'h00F0);
          chk("R6", "id exit", mode, 0);
        end else begin
          chk("R3", "other cmd mode", mode, 0);
          chk("R3", "other cmd no start", start_cnt, sc);
        end
      end
    end

    // Break each step of a chip erase sequence by data or by address
    for (int bm = 0; bm < 2; bm++) begin
      for (int p = 0; p < 5; p++) begin
        for (int k = 0; k < 2; k++) begin
          logic [11:0] aa [6];
          logic [7:0]  dd [6];
          byte_mode = bm[0];
          aa[0] = fa(); aa[1] = fb(); aa[2] = fa(); aa[3] = fa(); aa[4] = fb(); aa[5] = fa();
          dd[0] = 8'hAA; dd[1] = 8'h55; dd[2] = 8'h80; dd[3] = 8'hAA; dd[4] = 8'h55; dd[5] = 8'h10;
          if (k == 0) dd[p] = dd[p] ^ 8'h01; else aa[p] = aa[p] ^ 12'h001;
          sc = start_cnt;
          for (int i = 0; i < 6; i++) wr({8'h00, aa[i]}, {8'h00, dd[i]});
          chk("R3", "broken sequence no start", start_cnt, sc);
          chk("R3", "broken sequence mode", mode, 0);
        end
      end
      sc = start_cnt;
      do_prog(20'h0ABCD, 16'hBEEF);
      chk("R3", "recovery program", start_cnt, sc + 1);
      eng(1'b0);
    end

    // F0 drops a partial sequence
    byte_mode = 1'b0;
    sc = start_cnt;
    unlock();
    wr(20'h00555, 16'h00F0);
    wr(20'h00555, 16'h0080);
    unlock();
    wr(20'h00555, 16'h0010);
    chk("R7", "F0 after unlock", start_cnt, sc);
    unlock();
    wr(20'h00555, 16'h0080);
    wr(20'h7F000, 16'h00F0);
    unlock();
    wr(20'h00555, 16'h0010);
    chk("R7", "F0 inside erase", start_cnt, sc);
    chk("R7", "F0 mode", mode, 0);

    // Busy program ignores everything, then fails
    do_prog(20'h01000, 16'h1234);
    sc = start_cnt;
    wr(20'h00000, 16'h00F0);
    chk("R8", "F0 ignored in program", mode, 2);
    do_prog(20'h02000, 16'h5678);
    chk("R8", "no nested start", start_cnt, sc);
    eng(1'b1);
    chk("R8", "fail entered", mode, 5);
    do_prog(20'h03000, 16'h9ABC);
    chk("R9", "fail held", mode, 5);
    chk("R9", "no start in fail", start_cnt, sc);
    wr(20'h44444, 16'h00F0);
    chk("R9", "F0 leaves fail", mode, 0);

    // Chip erase cannot be suspended
    byte_mode = 1'b1;
    do_erase_pre();
    wr(20'h00AAA, 16'h0010);
    sc = susp_cnt;
    wr(20'h00000, 16'h00B0);
    chk("R10", "B0 ignored in chip erase", mode, 3);
    chk("R10", "no suspend pulse", susp_cnt, sc);
    wr(20'h00000, 16'h00F0);
    chk("R10", "F0 ignored in erase", mode, 3);
    eng(1'b1);
    chk("R10", "erase fail", mode, 5);
    wr(20'h00000, 16'h00F0);

    // Sector erase, suspend, program inside suspend, resume
    do_erase_pre();
    wr(20'h9A123, 16'h0030);
    chk("R5", "sector op", start_op, 3);
    chk("R5", "sector addr", start_addr, 20'h9A123);
    chk("R5", "sector mode", mode, 3);
    wr(20'h00AAA, 16'h0055);
    chk("R10", "other write ignored", mode, 3);
    sc = susp_cnt;
    wr(20'h31234, 16'h00B0);
    chk("R10", "suspend mode", mode, 4);
    chk("R10", "suspend pulse", susp_cnt, sc + 1);
    unlock();
    wr(20'h00AAA, 16'h0090);
    chk("R11", "ID refused", mode, 4);
    sc = start_cnt;
    do_erase_pre();
    wr(20'h00AAA, 16'h0010);
    chk("R11", "erase refused", start_cnt, sc);
    chk("R11", "still suspended", mode, 4);
    do_prog(20'h20202, 16'h00C3);
    chk("R11", "suspend program start", start_cnt, sc + 1);
    chk("R11", "suspend program mode", mode, 2);
    eng(1'b0);
    chk("R8", "back to suspended", mode, 4);
    sc = resm_cnt;
    wr(20'h00001, 16'h0030);
    chk("R11", "resume mode", mode, 3);
    chk("R11", "resume pulse", resm_cnt, sc + 1);
    eng(1'b0);
    chk("R10", "erase done", mode, 0);

    // Hardware reset during a busy program
    do_prog(20'h05555, 16'h7777);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "reset exits busy", mode, 0);
    @(negedge clk);
    rst_n = 1'b1;
    sc = start_cnt;
    wr(20'h06666, 16'h1111);
    chk("R1", "no pending op", start_cnt, sc);
    chk("R1", "read after reset", mode, 0);

    chk("R12", "pulses exclusive", multi_cnt, 0);
    chk("R12", "pulses single cycle", long_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule